// File: doc/BRIEF.md
# Aligned Prefetch Instruction Buffer

This block sits between a CPU instruction-fetch port and a slow memory that returns one aligned 64-bit line per read. When its enable bit is set, it reads lines ahead of the CPU into a small buffer that holds two lines. It then answers 16-bit and 32-bit instruction fetches from the buffer, usually in the same cycle the fetch is presented. A sequential stream of code therefore rarely waits on the memory. A fetch outside the buffered lines throws the buffer away and restarts the read-ahead at the new line.

The enable sits in bit 0 of a small option register and is off after reset. While it is off, the block does no read-ahead. Each fetch is served by reading exactly the line or lines it needs, and those lines are discarded afterwards. Fetches marked as data reads always take this direct path, even while the enable is set, so data is never served from read-ahead contents.

Addresses on the CPU side count 16-bit units. Line addresses on the memory side count 64-bit lines, so a line address is the unit address with its two low bits removed. At most one memory read is outstanding at a time.

Top module: `code_prefetch_buf`

## Requirements
- R1: After reset, `opt_rdata` is 0, `mem_req` is low and `cpu_ready` is low. With no fetch presented and the enable off, no memory read is issued.
- R2: In the option register, bit 0 is the read-ahead enable (1 = on) and takes `opt_wdata[0]` on a write. All other bits of `opt_rdata` read as 0.
- R3: With the enable off, each fetch causes exactly the memory reads it needs: one line, or two lines for a 32-bit fetch at unit offset 3. A repeated fetch of the same line reads memory again. No read starts without a fetch pending.
- R4: `mem_line` is the 64-bit line index, equal to the unit address divided by 4. Once `mem_req` is raised, it and `mem_line` stay unchanged until the cycle `mem_ready` is seen.
- R5: With the enable on and no fetch pending, the block reads successive lines until two are buffered, then stops. The first line read is the line of the most recent fetch, or line 0 after reset.
- R6: Unit k of a line (k = 0..3) is in bits 16k+15:16k. A 16-bit fetch returns its unit in `cpu_rdata[15:0]` with the upper half zero. A 32-bit fetch at unit address a returns unit a in [15:0] and unit a+1 in [31:16]. A fetch whose units are in the head line is answered in the cycle it is presented.
- R7: When a fetch uses the last unit of the head line, that line is dropped and the next sequential line is read.
- R8: A code fetch outside the buffered and in-flight lines empties the buffer and restarts reading at its own line. The data of a read already in flight is discarded.
- R9: A 32-bit fetch at unit offset 3 is answered only once both lines are held, and it carries the data of both.
- R10: A fetch with `cpu_code` low is served by a direct memory read of its line, even when that line is buffered, and empties the buffer.
- R11: Writing 0 to the enable empties the buffer, and the block returns to direct fetches: a line held before the write is read from memory again.
- R12: A code fetch whose units lie in the second buffered line drops the head line and is answered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | OPT_W | Option register write data |
| opt_rdata | output | OPT_W | Option register contents |
| cpu_req | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Fetch address in 16-bit units |
| cpu_is32 | input | 1 | 1 = 32-bit fetch, 0 = 16-bit fetch |
| cpu_code | input | 1 | 1 = instruction fetch, 0 = data read |
| cpu_ready | output | 1 | Fetch answered this cycle |
| cpu_rdata | output | 2*UNIT_W | Fetch data |
| mem_req | output | 1 | Line read request |
| mem_line | output | ADDR_W-2 | Line index of the read |
| mem_rdata | input | LINE_W | Line data, valid with `mem_ready` |
| mem_ready | input | 1 | Read completes this cycle |

## Verification
Four behaviours are checked on every cycle: the memory request holds its line address steady until it completes, the reserved option bits stay zero, no read starts while the enable is off unless a fetch is pending, and answers come only for a pending request, with the upper half zero for 16-bit fetches. Which lines are read and in what order, the data returned across line boundaries, the extra cycle when the buffer advances, the discarding of a stale in-flight read, and the re-reading after a data access or a disable can only be shown by the bench's scenarios. These scenarios compare a log of memory reads and the returned units with values computed from the address.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
   // Decision taken by the controller for the pending fetch in one cycle
   typedef enum logic [1:0] {
      ACT_IDLE    = 2'd0,   // nothing or waiting on memory
      ACT_SERVE   = 2'd1,   // answer the fetch from the head line(s)
      ACT_ADVANCE = 2'd2,   // drop the head line, fetch sits in the next one
      ACT_RESTART = 2'd3    // empty the buffer and restart at the fetch's line
   } pfb_act_e;
endpackage

// File: rtl/pfb_opt_reg.sv
module pfb_opt_reg #(
   parameter int OPT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [OPT_W-1:0] wdata,
   output logic [OPT_W-1:0] rdata,
   output logic             enable,
   output logic             clear
);
   logic en_q;
   logic unused_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= 1'b0;
      else if (we) en_q <= wdata[0];
   end

   assign unused_hi = ^wdata[OPT_W-1:1];
   assign enable    = en_q;
   assign clear     = we && !wdata[0] && en_q;
   assign rdata     = {{(OPT_W-1){1'b0}}, en_q};
endmodule

// File: rtl/pfb_line_store.sv
module pfb_line_store #(
   parameter int LINE_W = 64,
   parameter int DEPTH  = 2,
   parameter int IDX_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_data,
   output logic [LINE_W-1:0] head0,
   output logic [LINE_W-1:0] head1
);
   logic [DEPTH*LINE_W-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [LINE_W-1:0] ent;
      logic [LINE_W-1:0] shift_in;
      if (i == DEPTH-1) begin : g_last
         assign shift_in = ent;
      end else begin : g_mid
         assign shift_in = flat[(i+1)*LINE_W +: LINE_W];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               ent <= '0;
         else if (wr_en && wr_idx == IDX_W'(i))    ent <= wr_data;
         else if (pop)                             ent <= shift_in;
      end
      assign flat[i*LINE_W +: LINE_W] = ent;
   end

   assign head0 = flat[0 +: LINE_W];
   assign head1 = flat[LINE_W +: LINE_W];
endmodule

// File: rtl/pfb_unit_pick.sv
module pfb_unit_pick #(
   parameter int LINE_W = 64,
   parameter int UNIT_W = 16,
   parameter int OFS_W  = 2
) (
   input  logic [LINE_W-1:0]   head0,
   input  logic [LINE_W-1:0]   head1,
   input  logic [OFS_W-1:0]    ofs,
   input  logic                is32,
   output logic [2*UNIT_W-1:0] rdata
);
   logic [UNIT_W-1:0] lo, hi;
   logic [OFS_W-1:0]  nxt;

   assign nxt = ofs + OFS_W'(1);
   assign lo  = head0[int'(ofs)*UNIT_W +: UNIT_W];
   assign hi  = (&ofs) ? head1[UNIT_W-1:0] : head0[int'(nxt)*UNIT_W +: UNIT_W];
   assign rdata = is32 ? {hi, lo} : {{UNIT_W{1'b0}}, lo};
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
   import pfb_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int OFS_W  = 2,
   parameter int DEPTH  = 2,
   parameter int CNT_W  = 2,
   parameter int IDX_W  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    clear,
   input  logic                    cpu_req,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic                    cpu_is32,
   input  logic                    cpu_code,
   input  logic                    mem_ready,
   output logic                    mem_req,
   output logic [ADDR_W-OFS_W-1:0] mem_line,
   output logic                    serve,
   output logic                    pop,
   output logic                    wr_en,
   output logic [IDX_W-1:0]        wr_idx
);
   localparam int LA_W = ADDR_W - OFS_W;
   localparam logic [OFS_W-1:0] OFS_PEN = OFS_W'((1 << OFS_W) - 2);

   logic [LA_W-1:0]  base_q, base_d, line_q, line_d, req_line, diff;
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_pop, need, window;
   logic             infl_q, infl_d, stale_q, stale_d, dir_q, dir_d;
   logic [OFS_W-1:0] req_ofs;
   logic             straddle, ends_line, direct, ret, flush, issue, en_now;
   pfb_act_e         act;

   assign req_line  = cpu_addr[ADDR_W-1:OFS_W];
   assign req_ofs   = cpu_addr[OFS_W-1:0];
   assign straddle  = cpu_is32 && (&req_ofs);
   assign ends_line = (&req_ofs) || (cpu_is32 && req_ofs == OFS_PEN);
   assign need      = straddle ? CNT_W'(2) : CNT_W'(1);
   assign diff      = req_line - base_q;
   assign window    = cnt_q + CNT_W'(infl_q && !stale_q);
   assign ret       = infl_q && mem_ready;
   assign direct    = dir_q || !enable || !cpu_code;
   assign en_now    = enable && !clear;

   // decision for the pending fetch
   always_comb begin
      act   = ACT_IDLE;
      dir_d = dir_q;
      if (cpu_req) begin
         if (direct) begin
            if (!dir_q) begin
               act   = ACT_RESTART;
               dir_d = 1'b1;
            end else if (cnt_q >= need) begin
               act   = ACT_SERVE;
               dir_d = 1'b0;
            end
         end else if (cnt_q != '0 && diff == '0) begin
            if (cnt_q >= need) act = ACT_SERVE;
         end else if (diff < LA_W'(cnt_q)) begin
            act = ACT_ADVANCE;
         end else if (!(diff < LA_W'(window))) begin
            act = ACT_RESTART;
         end
      end
   end

   // buffer bookkeeping
   always_comb begin
      serve   = (act == ACT_SERVE);
      flush   = (act == ACT_RESTART) || clear || (serve && dir_q);
      pop     = !flush && ((act == ACT_ADVANCE) || (serve && ends_line));
      if (act == ACT_RESTART) base_d = req_line;
      else if (pop)           base_d = base_q + LA_W'(1);
      else                    base_d = base_q;
      cnt_pop = cnt_q - CNT_W'(pop);
      wr_en   = ret && !stale_q && !flush;
      wr_idx  = IDX_W'(cnt_pop);
      cnt_d   = flush ? '0 : cnt_pop + CNT_W'(wr_en);
      issue   = !infl_q && (dir_d ? (cpu_req && cnt_d < need)
                                  : (en_now && cnt_d < CNT_W'(DEPTH)));
      line_d  = issue ? base_d + LA_W'(cnt_d) : line_q;
      infl_d  = (infl_q && !ret) || issue;
      if (ret)                  stale_d = 1'b0;
      else if (flush && infl_q) stale_d = 1'b1;
      else                      stale_d = stale_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         line_q  <= '0;
         cnt_q   <= '0;
         infl_q  <= 1'b0;
         stale_q <= 1'b0;
         dir_q   <= 1'b0;
      end else begin
         base_q  <= base_d;
         line_q  <= line_d;
         cnt_q   <= cnt_d;
         infl_q  <= infl_d;
         stale_q <= stale_d;
         dir_q   <= dir_d;
      end
   end

   assign mem_req  = infl_q;
   assign mem_line = line_q;
endmodule

// File: rtl/code_prefetch_buf.sv
module code_prefetch_buf #(
   parameter int ADDR_W = 22,
   parameter int UNIT_W = 16,
   parameter int LINE_W = 64,
   parameter int DEPTH  = 2,
   parameter int OPT_W  = 16
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     opt_we,
   input  logic [OPT_W-1:0]                         opt_wdata,
   output logic [OPT_W-1:0]                         opt_rdata,
   input  logic                                     cpu_req,
   input  logic [ADDR_W-1:0]                        cpu_addr,
   input  logic                                     cpu_is32,
   input  logic                                     cpu_code,
   output logic                                     cpu_ready,
   output logic [2*UNIT_W-1:0]                      cpu_rdata,
   output logic                                     mem_req,
   output logic [ADDR_W-$clog2(LINE_W/UNIT_W)-1:0]  mem_line,
   input  logic [LINE_W-1:0]                        mem_rdata,
   input  logic                                     mem_ready
);
   localparam int UNITS = LINE_W / UNIT_W;
   localparam int OFS_W = $clog2(UNITS);
   localparam int LA_W  = ADDR_W - OFS_W;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   // elaboration-time parameter checks
   if (LINE_W % UNIT_W != 0 || (1 << OFS_W) != UNITS || UNITS < 2) begin : g_bad_line
      $error("line width must hold a power-of-two count of at least two units");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("buffer depth must be at least two lines");
   end
   if (LA_W <= CNT_W) begin : g_bad_addr
      $error("address too narrow for the buffer depth");
   end
   if (OPT_W < 2) begin : g_bad_opt
      $error("option register needs at least two bits");
   end

   logic              enable, clear, pop, wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [LINE_W-1:0] head0, head1;

   pfb_opt_reg #(.OPT_W(OPT_W)) u_opt (
      .clk(clk), .rst_n(rst_n), .we(opt_we), .wdata(opt_wdata),
      .rdata(opt_rdata), .enable(enable), .clear(clear)
   );

   pfb_ctrl #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
      .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_is32(cpu_is32), .cpu_code(cpu_code),
      .mem_ready(mem_ready), .mem_req(mem_req), .mem_line(mem_line),
      .serve(cpu_ready), .pop(pop), .wr_en(wr_en), .wr_idx(wr_idx)
   );

   pfb_line_store #(.LINE_W(LINE_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .pop(pop), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(mem_rdata), .head0(head0), .head1(head1)
   );

   pfb_unit_pick #(.LINE_W(LINE_W), .UNIT_W(UNIT_W), .OFS_W(OFS_W)) u_pick (
      .head0(head0), .head1(head1), .ofs(cpu_addr[OFS_W-1:0]),
      .is32(cpu_is32), .rdata(cpu_rdata)
   );
endmodule

// File: rtl/pfb_chk.sv
module pfb_chk #(
   parameter int OPT_W  = 16,
   parameter int UNIT_W = 16,
   parameter int LA_W   = 20
) (
   input logic                clk,
   input logic                rst_n,
   input logic [OPT_W-1:0]    opt_rdata,
   input logic                cpu_req,
   input logic                cpu_is32,
   input logic                cpu_ready,
   input logic [2*UNIT_W-1:0] cpu_rdata,
   input logic                mem_req,
   input logic [LA_W-1:0]     mem_line,
   input logic                mem_ready
);
   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_line)));

   // R2
   opt_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opt_rdata[OPT_W-1:1] == '0);

   // R3
   no_spec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && !opt_rdata[0]) |-> $past(cpu_req));

   // R6
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   // R6
   half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !cpu_is32) |-> (cpu_rdata[2*UNIT_W-1:UNIT_W] == '0));
endmodule

bind code_prefetch_buf pfb_chk #(.OPT_W(OPT_W), .UNIT_W(UNIT_W), .LA_W(LA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .opt_rdata(opt_rdata), .cpu_req(cpu_req),
   .cpu_is32(cpu_is32), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
   .mem_req(mem_req), .mem_line(mem_line), .mem_ready(mem_ready)
);

// File: tb/tb_code_prefetch_buf.sv
`timescale 1ns/100ps
module tb_code_prefetch_buf;
   localparam int AW = 22, UW = 16, LW = 64, D = 2, OW = 16, LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          opt_we = 1'b0;
   logic [OW-1:0] opt_wdata = '0;
   logic [OW-1:0] opt_rdata;
   logic          cpu_req = 1'b0, cpu_is32 = 1'b0, cpu_code = 1'b1;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_ready;
   logic [31:0]   cpu_rdata;
   logic          mem_req;
   logic [AW-3:0] mem_line;
   logic [LW-1:0] mem_rdata = '0;
   logic          mem_ready = 1'b0;

   code_prefetch_buf #(.ADDR_W(AW), .UNIT_W(UW), .LINE_W(LW), .DEPTH(D), .OPT_W(OW)) dut (
      .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata), .opt_rdata(opt_rdata),
      .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_is32(cpu_is32), .cpu_code(cpu_code),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_line(mem_line),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;

   function automatic logic [15:0] wv(input int unsigned w);
      return 16'((w * 947 + 90) & 32'hFFFF);
   endfunction
   function automatic logic [63:0] ld(input int unsigned l);
      return {wv(4*l+3), wv(4*l+2), wv(4*l+1), wv(4*l)};
   endfunction
   function automatic logic [31:0] ex(input int unsigned a, input bit w32);
      return w32 ? {wv(a+1), wv(a)} : {16'h0, wv(a)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   // memory model with fixed latency and a log of line reads
   int lat_cnt = 0;
   int unsigned flog[$];
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         lat_cnt   <= 0;
      end else begin
         mem_ready <= 1'b0;
         if (mem_req && !mem_ready) begin
            if (lat_cnt == LAT) begin
               mem_ready <= 1'b1;
               mem_rdata <= ld(int'(mem_line));
               lat_cnt   <= 0;
               flog.push_back(int'(mem_line));
            end else begin
               lat_cnt <= lat_cnt + 1;
            end
         end
      end
   end

   // scoreboard
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] m_e;
   string       m_t;
   always @(negedge clk) begin
      if (rst_n && cpu_req && cpu_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected answer", cpu_rdata, 0);
         end else begin
            m_e = exp_q.pop_front();
            m_t = tag_q.pop_front();
            chk(cpu_rdata == m_e, m_t, cpu_rdata, m_e);
         end
      end
   end

   task automatic fetch(input int unsigned a, input bit w32, input bit code,
                        input string tag, output int waits);
      exp_q.push_back(ex(a, w32));
      tag_q.push_back(tag);
      @(posedge clk); #1;
      cpu_addr = AW'(a); cpu_is32 = w32; cpu_code = code; cpu_req = 1'b1;
      waits = 0;
      forever begin
         @(negedge clk);
         if (cpu_ready) break;
         waits++;
         if (waits > 2000) break;
      end
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   task automatic opt_write(input logic [OW-1:0] v);
      @(posedge clk); #1;
      opt_we = 1'b1; opt_wdata = v;
      @(posedge clk); #1;
      opt_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      int w;
      int unsigned s;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk(opt_rdata == 0, "R1 opt_rdata", opt_rdata, 0);
      chk(mem_req == 0 && cpu_ready == 0, "R1 outputs idle", {mem_req, cpu_ready}, 0);
      idle(10);
      chk(flog.size() == 0, "R1 no reads while disabled", flog.size(), 0);

      // R3 pass-through
      fetch(5, 0, 1, "R3 direct data", w);
      chk(flog.size() == 1 && flog[0] == 1, "R3 one read of line 1", flog.size(), 1);
      fetch(5, 0, 1, "R3 repeat data", w);
      chk(flog.size() == 2 && flog[1] == 1, "R3 repeat reads again", flog.size(), 2);
      fetch(11, 1, 1, "R9 direct straddle data", w);
      chk(flog.size() == 4 && flog[2] == 2 && flog[3] == 3, "R9 direct straddle reads", flog.size(), 4);
      idle(10);
      chk(flog.size() == 4, "R3 no read-ahead while disabled", flog.size(), 4);

      // R2 option register
      opt_write(16'hFFFF);
      chk(opt_rdata == 16'h0001, "R2 enable set, reserved zero", opt_rdata, 1);

      // R5 read-ahead fills two lines starting at line 2
      idle(25);
      chk(flog.size() == 6 && flog[4] == 2 && flog[5] == 3, "R5 read-ahead lines", flog.size(), 6);
      idle(10);
      chk(flog.size() == 6, "R5 stops when full", flog.size(), 6);

      // R6 hits
      fetch(8, 0, 1, "R6 hit 16-bit", w);
      chk(w == 0, "R6 hit same cycle", w, 0);
      fetch(9, 1, 1, "R6 hit 32-bit", w);
      chk(w == 0, "R6 hit 32 same cycle", w, 0);
      // R7 consume end of line
      fetch(11, 0, 1, "R7 last unit data", w);
      idle(10);
      chk(flog.size() == 7 && flog[6] == 4, "R7 next line read", flog[flog.size()-1], 4);
      fetch(12, 1, 1, "R6 hit new head", w);
      chk(w == 0, "R6 hit after advance", w, 0);
      // R9 straddle with both lines held
      fetch(15, 1, 1, "R9 straddle data", w);
      chk(w == 0, "R9 straddle immediate", w, 0);
      idle(10);
      chk(flog.size() == 8 && flog[7] == 5, "R7 line 5 read", flog[flog.size()-1], 5);

      // R12 fetch in second line
      fetch(21, 0, 1, "R12 second line data", w);
      chk(w == 1, "R12 one cycle advance", w, 1);

      // R8 miss and stale discard
      fetch(400, 1, 1, "R8 miss data", w);
      chk(w >= LAT, "R8 miss waits for memory", w, LAT);
      fetch(2000, 0, 1, "R8 restart data", w);
      idle(25);
      s = flog.size();
      chk(flog[s-1] == 501 && flog[s-2] == 500, "R8 restart lines", flog[s-1], 501);

      // R10 data read bypasses buffer
      fetch(2001, 0, 0, "R10 data read data", w);
      chk(flog.size() > s && flog[s] == 500, "R10 direct read of buffered line", flog[s], 500);
      idle(25);

      // R11 disable flushes
      opt_write(16'h0000);
      chk(opt_rdata == 0, "R2 enable cleared", opt_rdata, 0);
      s = flog.size();
      idle(10);
      chk(flog.size() == s, "R11 no read-ahead after clear", flog.size(), s);
      fetch(2002, 0, 1, "R11 data after clear", w);
      chk(flog.size() == s + 1 && flog[s] == 500, "R11 line read again", flog.size(), s + 1);

      // R8 stale in-flight read discarded on restart
      opt_write(16'h0001);
      fetch(4000, 0, 1, "R8 stale discard data", w);
      fetch(4001, 1, 1, "R8 after restart hit", w);

      idle(5);
      chk(exp_q.size() == 0, "R6 all answers seen", exp_q.size(), 0);
      finish_up();
   end
endmodule